// File: doc/BRIEF.md
# DMA Completion Interrupt Router

This block gathers the completion interrupt levels of fifteen DMA channels and presents them through a small two-level interrupt register set. Each channel's level is captured once per clock into a per-channel status word. The channels are then folded onto twelve routed lines. The first eleven channels each own a line. The last four channels share the twelfth line through an OR.

The routed lines appear in a first-level pending word, starting at bit 16. A software-maintained enable mask selects which pending bits may raise the CPU. A basic pending word carries one summary bit, bit 8. That bit is set when any enabled first-level pending bit is set. The CPU interrupt request follows the basic word.

Pending bits reflect the current levels and are never latched. A channel that drops its flag clears its status bit and its line on the next capture. The register port is a simple one: a write strobe, and a read data bus driven combinationally from the address.

Top module: `dma_irq_router`

## Requirements
- R1: After reset, the enable mask is zero, the status, first-level pending and basic pending words read 0, and `cpuIrq` is 0.
- R2: The status word (address 0xFE0) has bit n equal to channel n's interrupt level as sampled on the previous rising clock edge.
- R3: Channels 0 to 10 each drive their own line k=n. Line k shows as bit 16+k of the first-level pending word (address 0x004), and no other bit changes.
- R4: Channels 11 to 14 are ORed onto line 11, which shows as pending bit 27. Any one of them, or several together, sets only that bit.
- R5: A write to the enable-set address (0x010) sets each enable bit whose write-data bit is 1 and leaves the other bits unchanged. The enable mask reads back at 0x010.
- R6: A write to the enable-clear address (0x01C) clears each enable bit whose write-data bit is 1 and leaves the other bits unchanged.
- R7: Basic pending (address 0x000) bit 8 is 1 exactly when the first-level pending word ANDed with the enable mask is nonzero. All of its other bits read 0. First-level pending bits are shown regardless of the enable mask.
- R8: `cpuIrq` is 1 exactly when the basic pending word is nonzero.
- R9: Pending is level-reflecting. Once every channel feeding a line has dropped, that line's pending bit reads 0 one edge later, without any software clear.
- R10: Writes to any address other than 0x010 and 0x01C leave the enable mask unchanged. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanIrq | input | 15 | Per-channel completion interrupt levels |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| cpuIrq | output | 1 | CPU interrupt request |

## Verification
The bench drives the channels at both ends of the dedicated range and at both ends of the shared range. A design that got the mapping off by one, or that gave channel 14 its own line, would set the wrong pending bit or leave bit 27 clear.

It also checks the enable mask in several ways. It sets masks in parts, clears them in parts, and writes to read-only addresses. A design that overwrote the mask instead of OR-ing into it, or that decoded writes loosely, would lose enable bits.

It checks that the summary bit and `cpuIrq` stay low while pending is raised but the line is masked. A design that left pending latched would keep bits set after a channel dropped.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_BASIC  = 12'h000;
  localparam logic [ADDR_W-1:0] ADDR_PEND   = 12'h004;
  localparam logic [ADDR_W-1:0] ADDR_EN_SET = 12'h010;
  localparam logic [ADDR_W-1:0] ADDR_EN_CLR = 12'h01C;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 12'hFE0;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic selBasic;
    logic selPend;
    logic selEnable;
    logic selStatus;
  } regStrobe_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe           = '0;
    strobe.enSet     = regWrEn && (regAddr == ADDR_EN_SET);
    strobe.enClr     = regWrEn && (regAddr == ADDR_EN_CLR);
    strobe.selBasic  = (regAddr == ADDR_BASIC);
    strobe.selPend   = (regAddr == ADDR_PEND);
    strobe.selEnable = (regAddr == ADDR_EN_SET) || (regAddr == ADDR_EN_CLR);
    strobe.selStatus = (regAddr == ADDR_STATUS);
  end
endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NUM_CHAN      = 15,
  parameter int NUM_DEDICATED = 11,
  parameter int LINE_BASE     = 16,
  parameter int SUMMARY_BIT   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CHAN-1:0] chanIrq,
  output logic [DATA_W-1:0] rdData,
  output logic              cpuIrq
);
  localparam int NUM_LINES   = NUM_DEDICATED + 1;
  localparam int SHARED_LINE = NUM_DEDICATED;
  localparam int SHARED_BIT  = LINE_BASE + SHARED_LINE;

  logic [NUM_CHAN-1:0] statusQ;
  logic [DATA_W-1:0]   enableQ;
  logic [NUM_LINES-1:0] lineVec;
  logic [DATA_W-1:0]   pendWord;
  logic [DATA_W-1:0]   basicWord;
  logic [DATA_W-1:0]   statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= chanIrq;
      if (strobe.enSet)      enableQ <= enableQ | wrData;
      else if (strobe.enClr) enableQ <= enableQ & ~wrData;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DEDICATED; gi++) begin : g_dedicated
      assign lineVec[gi] = statusQ[gi];
    end
  endgenerate
  assign lineVec[SHARED_LINE] = |statusQ[NUM_CHAN-1:NUM_DEDICATED];

  always_comb begin
    pendWord = '0;
    pendWord[LINE_BASE +: NUM_LINES] = lineVec;
    basicWord = '0;
    basicWord[SUMMARY_BIT] = |(pendWord & enableQ);
    statusWord = '0;
    statusWord[NUM_CHAN-1:0] = statusQ;
  end

  assign cpuIrq = |basicWord;

  always_comb begin
    rdData = '0;
    if (strobe.selBasic)  rdData = basicWord;
    if (strobe.selPend)   rdData = pendWord;
    if (strobe.selEnable) rdData = enableQ;
    if (strobe.selStatus) rdData = statusWord;
  end

  // R3
  dedicated_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanIrq[0] |=> pendWord[LINE_BASE]);
  // R4
  shared_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|chanIrq[NUM_CHAN-1:NUM_DEDICATED]) |=> pendWord[SHARED_BIT]);
  // R9
  level_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanIrq == '0) |=> (pendWord == '0 && !cpuIrq));
  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enSet |=> ((enableQ & $past(wrData)) == $past(wrData)));
  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enClr |=> ((enableQ & $past(wrData)) == '0));
  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.enSet || strobe.enClr) |=> $stable(enableQ));
endmodule

// File: rtl/dma_irq_router.sv
module dma_irq_router
  import dma_irq_pkg::*;
#(
  parameter int NUM_CHAN      = 15,
  parameter int NUM_DEDICATED = 11,
  parameter int LINE_BASE     = 16,
  parameter int SUMMARY_BIT   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CHAN-1:0] chanIrq,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                cpuIrq
);
  regStrobe_t strobe;

  dma_irq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  dma_irq_datapath #(
    .NUM_CHAN      (NUM_CHAN),
    .NUM_DEDICATED (NUM_DEDICATED),
    .LINE_BASE     (LINE_BASE),
    .SUMMARY_BIT   (SUMMARY_BIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .chanIrq (chanIrq),
    .rdData  (regRdData),
    .cpuIrq  (cpuIrq)
  );
endmodule

// File: tb/dma_irq_router_tb.sv
module dma_irq_router_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] chanIrq = '0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cpuIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  dma_irq_router u_dut (
    .clk(clk), .rstN(rstN), .chanIrq(chanIrq), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .cpuIrq(cpuIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic drive(input logic [14:0] v);
    @(negedge clk);
    chanIrq = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] lineBit(input int ch);
    return 32'h1 << (16 + ((ch > 10) ? 11 : ch));
  endfunction

  task automatic testReset();
    logic [31:0] d;
    rd(12'hFE0, d); check("R1 status", d, 0);
    rd(12'h004, d); check("R1 pend", d, 0);
    rd(12'h000, d); check("R1 basic", d, 0);
    rd(12'h010, d); check("R1 enable", d, 0);
    check("R1 cpuIrq", {31'b0, cpuIrq}, 0);
  endtask

  task automatic testChannel(input int ch, input string req);
    logic [31:0] d;
    wr(12'h010, lineBit(ch));
    drive(15'h1 << ch);
    rd(12'hFE0, d); check("R2 status", d, 32'h1 << ch);
    rd(12'h004, d); check(req, d, lineBit(ch));
    rd(12'h000, d); check("R7 summary", d, 32'h100);
    check("R8 cpuIrq high", {31'b0, cpuIrq}, 1);
    drive('0);
    rd(12'h004, d); check("R9 pend drop", d, 0);
    rd(12'hFE0, d); check("R9 status drop", d, 0);
    check("R9 cpuIrq drop", {31'b0, cpuIrq}, 0);
    wr(12'h01C, lineBit(ch));
  endtask

  task automatic testSharedGroup();
    logic [31:0] d;
    drive(15'b011_0000_0000_0000);
    rd(12'h004, d); check("R4 shared pair", d, 32'h1 << 27);
    rd(12'hFE0, d); check("R2 pair status", d, 32'h3000);
    drive('0);
  endtask

  task automatic testMasking();
    logic [31:0] d;
    drive(15'h0020);
    rd(12'h004, d); check("R7 pend unmasked view", d, 32'h1 << 21);
    rd(12'h000, d); check("R7 masked summary", d, 0);
    check("R8 masked cpuIrq", {31'b0, cpuIrq}, 0);
    wr(12'h010, 32'h1 << 20);
    rd(12'h000, d); check("R7 other line enabled", d, 0);
    wr(12'h010, 32'h1 << 21);
    rd(12'h000, d); check("R7 enabled summary", d, 32'h100);
    drive('0);
    wr(12'h01C, 32'hFFFF_FFFF);
  endtask

  task automatic testEnableOps();
    logic [31:0] d;
    wr(12'h010, 32'h0000_F000);
    wr(12'h010, 32'h00F0_0000);
    rd(12'h010, d); check("R5 set accumulates", d, 32'h00F0_F000);
    wr(12'h01C, 32'h0030_1000);
    rd(12'h01C, d); check("R6 partial clear", d, 32'h00C0_E000);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'hFE0, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h010, d); check("R10 ro writes ignored", d, 32'h00C0_E000);
    rd(12'h020, d); check("R10 unmapped read", d, 0);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h010, d); check("R6 full clear", d, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testChannel(0, "R3 ch0");
    testChannel(10, "R3 ch10");
    testChannel(11, "R4 ch11");
    testChannel(14, "R4 ch14");
    testSharedGroup();
    testMasking();
    testEnableOps();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule